// File: doc/BRIEF.md
# Power-of-Two Multiply Word Shifter

This block shifts or rotates a data word by a distance taken from a second operand. It does not use a cascade of multiplexer stages. The distance is decoded into a single set bit, that is, a power of two. The data word is then multiplied by that weight, so each bit lands in its new position as a result of the arithmetic. The multiplier operand is cut into narrow segments, 16 bits wide by default, and each segment yields one partial product. Together the partial products cover every distance from 0 to 31.

A two-bit operation code picks one of four functions:

- logical left shift
- logical right shift
- arithmetic right shift
- left rotate

Right shifts reuse the same multiplier. They multiply by the complementary weight and take the upper half of the double-width product. Arithmetic right shifts then OR in a sign mask derived from the same decoded weight. A rotate is the OR of the two product halves.

A parameter selects whether the result leaves through a register stage that loads when the output-enable input is high, or leaves combinationally.

Top module: `shf_mulshift`

## Requirements
- R1: The shift distance k is data amount bits [4:0] only (for the default 32-bit word); any value on the higher amount bits leaves the result unchanged.
- R2: Operation code 2'b00 gives the data shifted left by k with zeros entering at bit 0.
- R3: Operation code 2'b01 gives the data shifted right by k with zeros entering at bit 31; k = 0 returns the data unchanged.
- R4: Operation code 2'b10 gives the data shifted right by k with the vacated upper k bits set equal to data bit 31.
- R5: Operation code 2'b11 gives the data rotated left by k, bits leaving bit 31 re-entering at bit 0.
- R6: With the output register built (OUT_REG = 1), the result shows the function of the inputs sampled at a rising clock edge where the output enable is high, one cycle after that edge, and holds its value across edges where the output enable is low.
- R7: With the output register built, an active-low asynchronous reset clears the result to zero.
- R8: With the output register omitted (OUT_REG = 0), the result follows the inputs combinationally, and the output enable has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional result register |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_sel | input | 2 | Function code: 00 left, 01 logical right, 10 arithmetic right, 11 rotate left |
| data_in | input | W | Word to be shifted |
| amt_in | input | W | Second operand; its low log2(W) bits are the distance |
| out_en | input | 1 | Load enable for the result register |
| result | output | W | Shifted or rotated word |

## Verification
The bench builds two copies of the block at W = 32 and SEG = 16. One has OUT_REG = 1, so the load-enable timing, the hold behaviour and the reset value can be observed. The other has OUT_REG = 0, so the combinational path can be compared in the same cycle with the enable toggling freely. With a 16-wide segment, both partial products are exercised: distances below 16 use the low segment of the weight, and distances of 16 and above use the high segment. Sweeping all 32 distances for every function, with the upper amount bits randomised, also covers the k = 0 special case of the right shifts and the segment boundary at 16.

// File: rtl/shf_pkg.sv
package shf_pkg;
   typedef enum logic [1:0] {
      SHF_SLL = 2'b00,
      SHF_SRL = 2'b01,
      SHF_SRA = 2'b10,
      SHF_ROL = 2'b11
   } shf_op_e;
endpackage

// File: rtl/shf_onehot_dec.sv
// Turns a binary distance into a single-bit weight 2**amt.
module shf_onehot_dec #(
   parameter int W  = 32,
   parameter int AW = $clog2(W)
) (
   input  logic [AW-1:0] amt,
   output logic [W-1:0]  oh
);
   for (genvar i = 0; i < W; i++) begin : g_bit
      assign oh[i] = (amt == AW'(i));
   end
endmodule

// File: rtl/shf_pow2_mul.sv
// data x weight, built from W/SEG narrow partial products.
module shf_pow2_mul #(
   parameter int W   = 32,
   parameter int SEG = 16
) (
   input  logic [W-1:0]   data,
   input  logic [W-1:0]   oh,
   output logic [2*W-1:0] prod
);
   localparam int NSEG = W / SEG;
   localparam int PW   = W + SEG;
   localparam int PRW  = 2 * W;

   logic [PW-1:0] part [NSEG];

   for (genvar j = 0; j < NSEG; j++) begin : g_seg
      assign part[j] = PW'(data) * PW'(oh[j*SEG +: SEG]);
   end

   // At most one segment carries the weight, so OR equals the sum.
   always_comb begin
      prod = '0;
      for (int j = 0; j < NSEG; j++) begin
         prod = prod | (PRW'(part[j]) << (j * SEG));
      end
   end
endmodule

// File: rtl/shf_result_sel.sv
// Picks the function output from the two product halves.
module shf_result_sel
   import shf_pkg::*;
#(
   parameter int W  = 32,
   parameter int AW = $clog2(W)
) (
   input  shf_op_e        op,
   input  logic [W-1:0]   data,
   input  logic [AW-1:0]  amt,
   input  logic [W-1:0]   oh,
   input  logic [2*W-1:0] prod,
   output logic [W-1:0]   res
);
   logic [W-1:0] lo, hi, right_v, sign_mask;
   logic         nz;

   assign lo = prod[W-1:0];
   assign hi = prod[2*W-1:W];
   assign nz = |amt;
   // For right ops oh = 2**(W-k); every bit at or above it is vacated.
   assign sign_mask = (nz && data[W-1]) ? ~(oh - W'(1)) : '0;
   assign right_v   = nz ? hi : data;

   always_comb begin
      unique case (op)
         SHF_SLL: res = lo;
         SHF_SRL: res = right_v;
         SHF_SRA: res = right_v | sign_mask;
         default: res = lo | hi;
      endcase
   end
endmodule

// File: rtl/shf_mulshift.sv
module shf_mulshift
   import shf_pkg::*;
#(
   parameter int W       = 32,
   parameter int SEG     = 16,
   parameter int OUT_REG = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [1:0]   op_sel,
   input  logic [W-1:0] data_in,
   input  logic [W-1:0] amt_in,
   input  logic         out_en,
   output logic [W-1:0] result
);
   localparam int AW = $clog2(W);

   if (W != (1 << AW)) begin : g_bad_w
      $error("shf_mulshift: W must be a power of two");
   end
   if ((SEG < 1) || (W % SEG != 0)) begin : g_bad_seg
      $error("shf_mulshift: SEG must divide W");
   end
   if ((OUT_REG != 0) && (OUT_REG != 1)) begin : g_bad_reg
      $error("shf_mulshift: OUT_REG must be 0 or 1");
   end

   shf_op_e        op;
   logic [AW-1:0]  k, eff;
   logic           right_op;
   logic [W-1:0]   oh, comb;
   logic [2*W-1:0] prod;
   logic           unused_amt_hi;

   assign op            = shf_op_e'(op_sel);
   assign k             = amt_in[AW-1:0];
   assign unused_amt_hi = ^amt_in[W-1:AW];
   assign right_op      = (op == SHF_SRL) || (op == SHF_SRA);
   assign eff           = right_op ? (AW'(0) - k) : k;

   shf_onehot_dec #(.W(W), .AW(AW)) u_dec (.amt(eff), .oh(oh));

   shf_pow2_mul #(.W(W), .SEG(SEG)) u_mul (.data(data_in), .oh(oh), .prod(prod));

   shf_result_sel #(.W(W), .AW(AW)) u_sel (
      .op(op), .data(data_in), .amt(k), .oh(oh), .prod(prod), .res(comb)
   );

   if (OUT_REG == 1) begin : g_reg
      logic [W-1:0] res_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      res_q <= '0;
         else if (out_en) res_q <= comb;
      end
      assign result = res_q;

      a_r6_load: assert property (@(posedge clk) disable iff (!rst_n)
         out_en |=> result == $past(comb));
      a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
         !out_en |=> $stable(result));
   end else begin : g_comb
      assign result = comb;
   end

   a_r1_single_weight: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(oh) == 1);
   a_r2_sll_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (op == SHF_SLL && k != '0) |-> !comb[0]);
   a_r3_srl_top_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (op == SHF_SRL && k != '0) |-> !comb[W-1]);
   a_r4_sra_sign_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (op == SHF_SRA) |-> comb[W-1] == data_in[W-1]);
   a_r5_rot_keeps_bits: assert property (@(posedge clk) disable iff (!rst_n)
      (op == SHF_ROL) |-> $countones(comb) == $countones(data_in));
endmodule

// File: tb/tb_shf_mulshift.sv
module tb_shf_mulshift;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  op_sel = 2'b00;
   logic [31:0] data_in = '0;
   logic [31:0] amt_in = '0;
   logic        out_en = 1'b0;
   logic [31:0] res_reg, res_comb;

   int n_chk = 0;
   int n_fail = 0;
   logic [31:0] exp_q = '0;

   always #5 clk = ~clk;

   shf_mulshift #(.W(32), .SEG(16), .OUT_REG(1)) dut (
      .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .data_in(data_in),
      .amt_in(amt_in), .out_en(out_en), .result(res_reg));

   shf_mulshift #(.W(32), .SEG(16), .OUT_REG(0)) dut_comb (
      .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .data_in(data_in),
      .amt_in(amt_in), .out_en(out_en), .result(res_comb));

   // Golden model: five stages, stage i moves by 2**i when amount bit i is set.
   function automatic logic [31:0] ref_model(logic [1:0] op, logic [31:0] d, logic [4:0] k);
      logic [31:0] v = d;
      for (int i = 0; i < 5; i++) begin
         int s = 1 << i;
         if (k[i]) begin
            case (op)
               2'b00: v = v << s;
               2'b01: v = v >> s;
               2'b10: v = $unsigned($signed(v) >>> s);
               default: v = (v << s) | (v >> (32 - s));
            endcase
         end
      end
      return v;
   endfunction

   function automatic string req_of(logic [1:0] op);
      case (op)
         2'b00: return "R2";
         2'b01: return "R3";
         2'b10: return "R4";
         default: return "R5";
      endcase
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
      end
   endtask

   // Drive after a falling edge, check the combinational copy, then the register.
   task automatic step(logic [1:0] op, logic [31:0] d, logic [4:0] k,
                       logic [26:0] hi_bits, logic en, string ctag);
      op_sel  = op;
      data_in = d;
      amt_in  = {hi_bits, k};
      out_en  = en;
      #1;
      check(ctag, res_comb, ref_model(op, d, k));
      @(posedge clk);
      if (en) exp_q = ref_model(op, d, k);
      #1;
      check(en ? {req_of(op), "/R6 load"} : "R6 hold", res_reg, exp_q);
      @(negedge clk);
   endtask

   initial begin
      #2_000_000;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      logic [31:0] pats [3];
      pats[0] = 32'hFFFF_FFFF;
      pats[1] = 32'h8000_0000;
      pats[2] = 32'h0;

      // R7: reset value of the registered copy
      @(negedge clk);
      data_in = 32'hDEAD_BEEF;
      out_en  = 1'b1;
      @(posedge clk);
      #1;
      check("R7 reset", res_reg, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;
      out_en = 1'b0;
      @(negedge clk);

      // R2..R5 with R1: every function, every distance, fixed and random data.
      for (int op = 0; op < 4; op++) begin
         for (int k = 0; k < 32; k++) begin
            pats[2] = $urandom;
            for (int p = 0; p < 3; p++) begin
               step(2'(op), pats[p], 5'(k), 27'($urandom), 1'b1,
                    {req_of(2'(op)), "/R1"});
            end
         end
      end

      // R6 hold and R8 enable independence: enable low on alternating steps.
      for (int i = 0; i < 40; i++) begin
         step(2'($urandom), $urandom, 5'($urandom), 27'($urandom),
              1'(i % 2), "R8");
      end

      // R7: asynchronous clear in the middle of a cycle
      rst_n = 1'b0;
      #1;
      check("R7 async", res_reg, 32'h0);
      exp_q = '0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule